// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block sits at the output of a two-channel receive path. It takes signed samples from channel A and channel B, each with its own valid strobe, and places them on the output pins. The samples go out in one of two ways: on two separate parallel buses, or time-multiplexed onto one shared bus. On the shared bus a sync pin shows which channel is being driven in each slot.

Each sample can be sent unchanged as two's complement, or converted to offset binary by flipping its sign bit. Either channel can be switched off with an enable mask. A disabled channel's strobe is ignored, so single-channel use produces no empty slots. Every output comes from a register. The mode and the number format are captured when a sample pair is accepted, so a control change can never split an A/B pair on the shared bus.

Top module: `dcf_top`

## Requirements
- R1: While rst_ni is low, and after its release until the first accepted sample, bus_a_o and bus_b_o are zero and sync_o and valid_o are low.
- R2: In parallel mode (mux_mode_i=0), when both enabled channels strobe together, the next cycle shows channel A on bus_a_o and channel B on bus_b_o, with valid_o high and sync_o low.
- R3: In shared mode (mux_mode_i=1), when both enabled channels strobe, the first cycle after acceptance shows A on bus_a_o with sync_o=1. The cycle after that shows B on bus_a_o with sync_o=0. valid_o is high in both cycles and bus_b_o is zero in both.
- R4: With offset_bin_i=1, each emitted sample equals the input with bit DATA_W-1 inverted. With offset_bin_i=0, the sample is emitted unchanged.
- R5: chan_en_i bit 0 enables A and bit 1 enables B. A strobe on a disabled channel is ignored. In parallel mode that channel's bus is zero, and in shared mode no slot is emitted for it.
- R6: In shared mode with only one channel contributing, only that channel is emitted, with sync_o=1 for A and sync_o=0 for B. sync_o keeps its last value in cycles where valid_o is low.
- R7: In shared mode, strobes that arrive in the cycle the B slot is being produced are dropped. They give no output.
- R8: Mode and format are captured at acceptance. Changing mux_mode_i or offset_bin_i while the B slot is pending does not alter that slot.
- R9: In a cycle with nothing accepted and nothing pending, valid_o goes low and all bus outputs and sync_o keep their previous values.
- R10: In parallel mode with only one channel strobing, that channel's bus carries its sample, the other bus is zero, valid_o is high and sync_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_data_i | input | DATA_W | Channel A sample, two's complement |
| a_valid_i | input | 1 | Channel A sample strobe |
| b_data_i | input | DATA_W | Channel B sample, two's complement |
| b_valid_i | input | 1 | Channel B sample strobe |
| mux_mode_i | input | 1 | 0: parallel buses, 1: shared bus |
| offset_bin_i | input | 1 | 1: emit offset binary |
| chan_en_i | input | 2 | Channel enables (bit 0 A, bit 1 B) |
| bus_a_o | output | DATA_W | Bus A, also the shared bus |
| bus_b_o | output | DATA_W | Bus B, zero in shared mode |
| sync_o | output | 1 | Shared-bus channel marker, high for A |
| valid_o | output | 1 | Output slot carries data |

## Verification
The assertions assume that the inputs are stable around each rising edge. They also assume that a strobe arriving during a pending B slot is a loss the system accepts, not an error. The properties therefore check slot order, sync levels and the idle hold without tying input timing to the output rate. The stimulus changes inputs only on falling edges. It includes directed back-to-back strobes in shared mode to reach the drop case, mode and format flips during a pending pair, and a random phase where strobes, enables, mode and format all vary freely.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    OUT_PARALLEL = 1'b0,
    OUT_SHARED   = 1'b1
  } out_mode_e;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_A   = 0;
  localparam int unsigned CH_B   = 1;
endpackage

// File: rtl/dcf_fmt.sv
module dcf_fmt #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic              offset_bin_i,
  output logic [DATA_W-1:0] fmt_o
);
  localparam int unsigned MSB = DATA_W - 1;

  always_comb begin
    fmt_o      = raw_i;
    fmt_o[MSB] = raw_i[MSB] ^ offset_bin_i;
  end
endmodule

// File: rtl/dcf_slot_ctrl.sv
module dcf_slot_ctrl
  import dcf_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CH-1:0]    hit_i,
  input  logic [DATA_W-1:0]    fmt_a_i,
  input  logic [DATA_W-1:0]    fmt_b_i,
  input  out_mode_e            mode_i,
  output logic [DATA_W-1:0]    bus_a_o,
  output logic [DATA_W-1:0]    bus_b_o,
  output logic                 sync_o,
  output logic                 valid_o
);
  logic              pend_q;
  logic [DATA_W-1:0] pend_data_q;
  logic              accept;

  // no new pair while the second shared slot is owed
  assign accept = !pend_q && (|hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_a_o     <= '0;
      bus_b_o     <= '0;
      sync_o      <= 1'b0;
      valid_o     <= 1'b0;
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else begin
      valid_o <= 1'b0;
      if (pend_q) begin
        bus_a_o <= pend_data_q;
        bus_b_o <= '0;
        sync_o  <= 1'b0;
        valid_o <= 1'b1;
        pend_q  <= 1'b0;
      end else if (accept) begin
        valid_o <= 1'b1;
        if (mode_i == OUT_SHARED) begin
          bus_b_o <= '0;
          if (hit_i[CH_A]) begin
            bus_a_o     <= fmt_a_i;
            sync_o      <= 1'b1;
            pend_q      <= hit_i[CH_B];
            pend_data_q <= fmt_b_i;
          end else begin
            bus_a_o <= fmt_b_i;
            sync_o  <= 1'b0;
          end
        end else begin
          bus_a_o <= hit_i[CH_A] ? fmt_a_i : '0;
          bus_b_o <= hit_i[CH_B] ? fmt_b_i : '0;
          sync_o  <= 1'b0;
        end
      end
    end
  end

  a_r3_b_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |=> (valid_o && !sync_o && bus_b_o == '0));

  a_r3_a_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_i == OUT_SHARED && hit_i[CH_A]) |=> (valid_o && sync_o));

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pend_q || accept) |=> (!valid_o && $stable(sync_o) && $stable(bus_a_o) && $stable(bus_b_o)));

  a_r10_parallel_sync_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_i == OUT_PARALLEL) |=> (valid_o && !sync_o));

  a_r5_disabled_b_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && mode_i == OUT_PARALLEL && !hit_i[CH_B]) |=> bus_b_o == '0);
endmodule

// File: rtl/dcf_top.sv
module dcf_top
  import dcf_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] a_data_i,
  input  logic              a_valid_i,
  input  logic [DATA_W-1:0] b_data_i,
  input  logic              b_valid_i,
  input  logic              mux_mode_i,
  input  logic              offset_bin_i,
  input  logic [1:0]        chan_en_i,
  output logic [DATA_W-1:0] bus_a_o,
  output logic [DATA_W-1:0] bus_b_o,
  output logic              sync_o,
  output logic              valid_o
);
  logic [NUM_CH-1:0][DATA_W-1:0] raw;
  logic [NUM_CH-1:0][DATA_W-1:0] fmt;
  logic [NUM_CH-1:0]             vld;
  logic [NUM_CH-1:0]             hit;
  out_mode_e                     mode;

  assign raw[CH_A] = a_data_i;
  assign raw[CH_B] = b_data_i;
  assign vld[CH_A] = a_valid_i;
  assign vld[CH_B] = b_valid_i;
  assign mode      = out_mode_e'(mux_mode_i);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign hit[ch] = vld[ch] & chan_en_i[ch];
    dcf_fmt #(.DATA_W(DATA_W)) u_fmt (
      .raw_i        (raw[ch]),
      .offset_bin_i (offset_bin_i),
      .fmt_o        (fmt[ch])
    );
  end

  dcf_slot_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .fmt_a_i (fmt[CH_A]),
    .fmt_b_i (fmt[CH_B]),
    .mode_i  (mode),
    .bus_a_o (bus_a_o),
    .bus_b_o (bus_b_o),
    .sync_o  (sync_o),
    .valid_o (valid_o)
  );
endmodule

// File: tb/dcf_top_tb.sv
module dcf_top_tb;
  localparam int W = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [W-1:0]  a_data_i = '0, b_data_i = '0;
  logic          a_valid_i = 1'b0, b_valid_i = 1'b0;
  logic          mux_mode_i = 1'b0, offset_bin_i = 1'b0;
  logic [1:0]    chan_en_i = 2'b11;
  logic [W-1:0]  bus_a_o, bus_b_o;
  logic          sync_o, valid_o;

  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  dcf_top #(.DATA_W(W)) u_dut (
    .clk_i, .rst_ni, .a_data_i, .a_valid_i, .b_data_i, .b_valid_i,
    .mux_mode_i, .offset_bin_i, .chan_en_i,
    .bus_a_o, .bus_b_o, .sync_o, .valid_o
  );

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         s;
  } slot_t;

  slot_t        q[$];
  logic [W-1:0] e_a = '0, e_b = '0;
  logic         e_s = 1'b0, e_v = 1'b0;

  function automatic logic [W-1:0] conv(logic [W-1:0] x, logic ob);
    return ob ? (x ^ (W'(1) << (W - 1))) : x;
  endfunction

  // reference model: queue of owed slots
  always @(posedge clk_i or negedge rst_ni) begin
    slot_t t;
    logic ha, hb;
    if (!rst_ni) begin
      e_a = '0; e_b = '0; e_s = 1'b0; e_v = 1'b0;
      q.delete();
    end else begin
      ha = a_valid_i && chan_en_i[0];
      hb = b_valid_i && chan_en_i[1];
      e_v = 1'b0;
      if (q.size() > 0) begin
        t = q.pop_front();
        e_a = t.a; e_b = t.b; e_s = t.s; e_v = 1'b1;
      end else if (ha || hb) begin
        e_v = 1'b1;
        if (mux_mode_i) begin
          if (ha) q.push_back('{conv(a_data_i, offset_bin_i), '0, 1'b1});
          if (hb) q.push_back('{conv(b_data_i, offset_bin_i), '0, 1'b0});
          t = q.pop_front();
          e_a = t.a; e_b = t.b; e_s = t.s;
        end else begin
          e_a = ha ? conv(a_data_i, offset_bin_i) : '0;
          e_b = hb ? conv(b_data_i, offset_bin_i) : '0;
          e_s = 1'b0;
        end
      end
    end
  end

  task automatic cmp(string tag);
    total++;
    if (bus_a_o !== e_a || bus_b_o !== e_b || sync_o !== e_s || valid_o !== e_v) begin
      bad++;
      $display("FAIL %s: got a=%h b=%h s=%b v=%b exp a=%h b=%h s=%b v=%b",
               tag, bus_a_o, bus_b_o, sync_o, valid_o, e_a, e_b, e_s, e_v);
    end
  endtask

  task automatic drv(logic [W-1:0] a, logic av, logic [W-1:0] b, logic bv,
                     logic md, logic ob, logic [1:0] en, string tag);
    a_data_i = a; a_valid_i = av; b_data_i = b; b_valid_i = bv;
    mux_mode_i = md; offset_bin_i = ob; chan_en_i = en;
    @(negedge clk_i);
    cmp(tag);
  endtask

  task automatic idle(string tag);
    drv('0, 1'b0, '0, 1'b0, mux_mode_i, offset_bin_i, chan_en_i, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cmp("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R1 after release");

    // R2 parallel pairs
    drv(12'h123, 1, 12'h456, 1, 0, 0, 2'b11, "R2");
    drv(12'hF00, 1, 12'h801, 1, 0, 0, 2'b11, "R2 negative");
    // R9 idle hold
    idle("R9"); idle("R9");
    // R4 format
    drv(12'h800, 1, 12'h7FF, 1, 0, 1, 2'b11, "R4 extremes");
    drv(12'h000, 1, 12'hFFF, 1, 0, 1, 2'b11, "R4 zero");
    // R10 single channel parallel
    drv(12'h0AA, 1, 12'h0BB, 0, 0, 0, 2'b11, "R10 only A");
    drv(12'h0AA, 0, 12'h0BB, 1, 0, 0, 2'b11, "R10 only B");
    // R5 disabled channels
    drv(12'h111, 1, 12'h222, 1, 0, 0, 2'b01, "R5 B off parallel");
    drv(12'h333, 1, 12'h444, 0, 1, 0, 2'b10, "R5 A off shared");
    idle("R5");
    // R3 shared pair
    drv(12'h5A5, 1, 12'hA5A, 1, 1, 0, 2'b11, "R3 slot A");
    idle("R3 slot B");
    idle("R9 after pair");
    // R6 single-channel shared, sync held
    drv(12'h321, 1, 12'h654, 1, 1, 0, 2'b01, "R6 A only");
    idle("R6 hold high"); idle("R6 hold high");
    drv(12'h321, 1, 12'h654, 1, 1, 0, 2'b10, "R6 B only");
    idle("R6 hold low");
    // R7 strobes during the B slot are dropped
    drv(12'h010, 1, 12'h020, 1, 1, 0, 2'b11, "R7 slot A");
    drv(12'h030, 1, 12'h040, 1, 1, 0, 2'b11, "R7 slot B");
    idle("R7 dropped");
    // R8 control flip while B pending
    drv(12'h812, 1, 12'h834, 1, 1, 0, 2'b11, "R8 slot A");
    drv(12'h000, 0, 12'h000, 0, 0, 1, 2'b11, "R8 slot B unchanged");
    idle("R8");

    // random mix
    for (int i = 0; i < 400; i++) begin
      drv(W'($urandom), 1'($urandom), W'($urandom), 1'($urandom),
          1'($urandom), 1'($urandom), 2'($urandom), "R2,R3,R4,R5 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule